// File: doc/BRIEF.md
# Synchronous Character Receiver with Sync Hunt

This block receives one synchronous serial line. Each bit is taken on a sample strobe that comes either from rising edges of a receive clock supplied by the modem, resynchronised into the system clock domain, or from an internal baud generator that divides the system clock down to one of four rates. Before any data is framed, the receiver searches the bit stream for a sync character. That character is one of two 8-bit codes shared by a group of lines, and a per-line select bit picks which one this receiver uses.

A state machine controls framing. In `ST_HUNT` it compares the most recent eight bits with the selected code on every bit. A match moves it to `ST_DATA` in one-sync mode, or to `ST_CONFIRM` in two-sync mode. In `ST_CONFIRM` it collects one full character. If that character is the code again, it goes to `ST_DATA`. Otherwise it goes back to `ST_HUNT`, which carries on bit by bit with the history it already holds. In `ST_DATA` it assembles 5 to 8 data bits, least significant bit first. When the character is complete it either delivers it or, with parity on, moves to `ST_PARITY`. `ST_PARITY` takes the parity bit, delivers the character with its error flag and returns to `ST_DATA`. The host resync input forces `ST_HUNT` from any state.

Top module: `sync_char_rx`

## Requirements
- R1: While reset is asserted, `char_valid`, `par_err` and `in_sync` are 0, and `char_out` is 0 after reset.
- R2: `cfg_len` sets the data length: 0 gives 8 bits, 1 gives 7, 2 gives 6 and 3 gives 5. Bits arrive least significant first. Each delivered character is right-justified in `char_out`, and every bit above the data length is 0.
- R3: With `cfg_par_en`=1, one parity bit follows the data bits. `cfg_par_odd`=1 selects odd parity and 0 selects even parity. `par_err` pulses together with `char_valid` when the total count of ones over the data and parity bits has the wrong sense. With `cfg_par_en`=0 there is no parity bit and `par_err` stays 0.
- R4: In hunt, the last eight received bits are compared with the sync code on every sample strobe. The oldest of these bits is the code's bit 0. A match is accepted only once eight bits have been received since reset or resync.
- R5: With `cfg_two_sync`=1, a first match leads to one full 8-bit character. Lock is reached only if that character equals the code. Otherwise hunting continues bit by bit and `in_sync` stays 0.
- R6: `cfg_sync_sel`=0 selects `sync_code_a` and 1 selects `sync_code_b`.
- R7: Sync characters used for acquisition are never delivered. Once locked, every character is delivered, including one equal to the sync code, with a `char_valid` pulse lasting one clock.
- R8: A one-clock pulse on `resync` returns the receiver to hunt on the next clock and drops the partial character and the hunt history.
- R9: With `ext_clk_present`=1, bits are taken on rising edges of `ext_rx_clk`. The state update lands on the third system clock after the edge is presented. With `ext_clk_present`=0, the internal strobe is used.
- R10: The internal strobe period is (CLK_HZ/BASE_BAUD) >> `cfg_baud` system clocks, so codes 0 to 3 give 1x, 2x, 4x and 8x the base rate. The first strobe falls that many clocks after reset is released.
- R11: `in_sync` is 1 exactly while the receiver is locked, in data or parity framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 2 | Data length code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even parity |
| cfg_two_sync | input | 1 | Require two sync characters |
| cfg_sync_sel | input | 1 | Choose sync code A (0) or B (1) |
| sync_code_a | input | 8 | Shared sync code A |
| sync_code_b | input | 8 | Shared sync code B |
| cfg_baud | input | 2 | Internal rate select |
| ext_clk_present | input | 1 | Modem supplies receive clock |
| ext_rx_clk | input | 1 | Modem receive clock |
| rx_data | input | 1 | Serial data |
| resync | input | 1 | Return to hunt |
| char_out | output | 8 | Delivered character |
| char_valid | output | 1 | One-clock delivery strobe |
| par_err | output | 1 | Parity error with the strobe |
| in_sync | output | 1 | Receiver locked |

## Verification
Several properties are checked on every cycle: the delivery strobe never lasts two cycles, the parity flag never appears without a strobe or with parity disabled, unused upper bits are zero, a resync clears the lock, and lock begins only on a sample strobe. Other behaviour can only be shown by the bench's scenarios. These are the hunt match on the correct code, a failed confirmation in two-sync mode, parity sense and corruption, a data character equal to the sync code, a discarded partial character, and the exact divider period and first-strobe time. A behavioural model checks them against the outputs on every clock.

// File: rtl/syncrx_pkg.sv
package syncrx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_DATA    = 2'd2,
        ST_PARITY  = 2'd3
    } rx_state_e;

    localparam int CHAR_W = 8;

    // Data length from the 2-bit length code: 0..3 -> 8..5 bits.
    function automatic logic [3:0] char_bits(input logic [1:0] code);
        return 4'd8 - {2'b00, code};
    endfunction

endpackage

// File: rtl/syncrx_baud_gen.sv
module syncrx_baud_gen #(
    parameter int CLK_HZ    = 50_000_000,
    parameter int BASE_BAUD = 1200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_sel,
    output logic       tick
);
    localparam int BASE_DIV = CLK_HZ / BASE_BAUD;
    localparam int CW       = $clog2(BASE_DIV + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] div_m1;

    assign div_m1 = (CW'(BASE_DIV) >> rate_sel) - CW'(1);
    assign tick   = (cnt_q >= div_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/syncrx_clk_sel.sv
module syncrx_clk_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_present,
    input  logic ext_clk,
    input  logic int_tick,
    output logic bit_stb
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_q;
    logic         prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[MSB-1:0], ext_clk};
            prev_q <= sync_q[MSB];
        end
    end

    assign bit_stb = ext_present ? (sync_q[MSB] & ~prev_q) : int_tick;
endmodule

// File: rtl/sync_char_rx.sv
module sync_char_rx
    import syncrx_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int BASE_BAUD   = 1200,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_sync,
    input  logic              cfg_sync_sel,
    input  logic [CHAR_W-1:0] sync_code_a,
    input  logic [CHAR_W-1:0] sync_code_b,
    input  logic [1:0]        cfg_baud,
    input  logic              ext_clk_present,
    input  logic              ext_rx_clk,
    input  logic              rx_data,
    input  logic              resync,
    output logic [CHAR_W-1:0] char_out,
    output logic              char_valid,
    output logic              par_err,
    output logic              in_sync
);
    localparam logic [3:0] FULL = 4'(CHAR_W);

    logic int_tick;
    logic bit_stb;

    syncrx_baud_gen #(
        .CLK_HZ   (CLK_HZ),
        .BASE_BAUD(BASE_BAUD)
    ) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .rate_sel(cfg_baud),
        .tick    (int_tick)
    );

    syncrx_clk_sel #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_csel (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_present(ext_clk_present),
        .ext_clk    (ext_rx_clk),
        .int_tick   (int_tick),
        .bit_stb    (bit_stb)
    );

    rx_state_e         state_q, state_d;
    logic [CHAR_W-1:0] hunt_q, hunt_shift, sync_code;
    logic [3:0]        fill_q;
    logic [2:0]        cnt_q;
    logic [CHAR_W-1:0] asm_q, asm_with_bit;
    logic [3:0]        nbits;
    logic              hunt_hit, last_data;
    logic              emit, emit_err;
    logic [CHAR_W-1:0] emit_char;

    // Shared decode of the current bit
    always_comb begin
        sync_code    = cfg_sync_sel ? sync_code_b : sync_code_a;
        hunt_shift   = {rx_data, hunt_q[CHAR_W-1:1]};
        hunt_hit     = (fill_q >= FULL - 4'd1) && (hunt_shift == sync_code);
        nbits        = char_bits(cfg_len);
        last_data    = ({1'b0, cnt_q} == nbits - 4'd1);
        asm_with_bit = asm_q | (CHAR_W'(rx_data) << cnt_q);
    end

    // Next state and delivery decision
    always_comb begin
        state_d   = state_q;
        emit      = 1'b0;
        emit_err  = 1'b0;
        emit_char = asm_with_bit;
        if (resync) begin
            state_d = ST_HUNT;
        end else if (bit_stb) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (hunt_hit)
                        state_d = cfg_two_sync ? ST_CONFIRM : ST_DATA;
                end
                ST_CONFIRM: begin
                    if (cnt_q == 3'd7)
                        state_d = hunt_hit ? ST_DATA : ST_HUNT;
                end
                ST_DATA: begin
                    if (last_data) begin
                        if (cfg_par_en) state_d = ST_PARITY;
                        else            emit    = 1'b1;
                    end
                end
                ST_PARITY: begin
                    emit      = 1'b1;
                    emit_char = asm_q;
                    emit_err  = ((^asm_q) ^ rx_data) != cfg_par_odd;
                    state_d   = ST_DATA;
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // Hunt history, bit counter and character assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hunt_q <= '0;
            fill_q <= '0;
            cnt_q  <= '0;
            asm_q  <= '0;
        end else if (resync) begin
            hunt_q <= '0;
            fill_q <= '0;
            cnt_q  <= '0;
            asm_q  <= '0;
        end else if (bit_stb) begin
            hunt_q <= hunt_shift;
            if (fill_q < FULL) fill_q <= fill_q + 4'd1;
            unique case (state_q)
                ST_HUNT: begin
                    cnt_q <= '0;
                    asm_q <= '0;
                end
                ST_CONFIRM: begin
                    cnt_q <= cnt_q + 3'd1;
                    asm_q <= '0;
                end
                ST_DATA: begin
                    if (last_data) begin
                        cnt_q <= '0;
                        asm_q <= cfg_par_en ? asm_with_bit : '0;
                    end else begin
                        cnt_q <= cnt_q + 3'd1;
                        asm_q <= asm_with_bit;
                    end
                end
                ST_PARITY: begin
                    cnt_q <= '0;
                    asm_q <= '0;
                end
                default: begin
                    cnt_q <= '0;
                    asm_q <= '0;
                end
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            char_out   <= '0;
            char_valid <= 1'b0;
            par_err    <= 1'b0;
        end else begin
            char_valid <= emit;
            par_err    <= emit & emit_err;
            if (emit) char_out <= emit_char;
        end
    end

    assign in_sync = (state_q == ST_DATA) || (state_q == ST_PARITY);

endmodule

// File: rtl/syncrx_chk.sv
module syncrx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       resync,
    input logic       bit_stb,
    input logic       cfg_par_en,
    input logic [1:0] cfg_len,
    input logic [7:0] char_out,
    input logic       char_valid,
    input logic       par_err,
    input logic       in_sync
);
    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!char_valid && !par_err && !in_sync);
        end
    end

    // R7
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> !char_valid);

    // R3
    par_err_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> (char_valid && cfg_par_en));

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> ((char_out >> (4'd8 - {2'b00, cfg_len})) == 8'd0));

    // R8
    resync_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> !in_sync);

    // R11
    valid_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> in_sync);

    // R9
    lock_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> $past(bit_stb));
endmodule

bind sync_char_rx syncrx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .resync    (resync),
    .bit_stb   (bit_stb),
    .cfg_par_en(cfg_par_en),
    .cfg_len   (cfg_len),
    .char_out  (char_out),
    .char_valid(char_valid),
    .par_err   (par_err),
    .in_sync   (in_sync)
);

// File: tb/tb_sync_char_rx.sv
module tb_sync_char_rx;
    localparam int CLK_HZ = 96000;
    localparam int BASE   = 1200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_len = 2'd0;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_sync = 1'b0, cfg_sync_sel = 1'b0;
    logic [7:0] sync_a = 8'h2D, sync_b = 8'hB4;
    logic [1:0] cfg_baud = 2'd0;
    logic       ext_clk_present = 1'b1, ext_rx_clk = 1'b0, rx_data = 1'b0, resync = 1'b0;
    logic [7:0] char_out;
    logic       char_valid, par_err, in_sync;

    sync_char_rx #(.CLK_HZ(CLK_HZ), .BASE_BAUD(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_two_sync(cfg_two_sync), .cfg_sync_sel(cfg_sync_sel),
        .sync_code_a(sync_a), .sync_code_b(sync_b), .cfg_baud(cfg_baud),
        .ext_clk_present(ext_clk_present), .ext_rx_clk(ext_rx_clk), .rx_data(rx_data),
        .resync(resync), .char_out(char_out), .char_valid(char_valid),
        .par_err(par_err), .in_sync(in_sync)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    int checks = 0, errs = 0;
    int nvalid = 0, nerr = 0;
    int vtimes[$];
    int vdata[$];
    bit checking = 0;
    string cur_req = "R1";
    int r_rel = 0;

    // behavioural reference model state
    bit hist[$];
    int m_state = 0, m_cnt = 0, m_val = 0;
    int v_due = -1, v_data = 0, v_err = 0;
    int ins_due = -1;
    bit ins_pend = 0, exp_insync = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errs++;
            $display("FAIL %s %s: got=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cyc == 150000) begin
            errs++; checks++;
            $display("FAIL watchdog: got=%0d expected=%0d", cyc, 0);
            finish_run();
        end
    end

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && char_valid) begin
            nvalid++;
            if (par_err) nerr++;
            vtimes.push_back(cyc);
            vdata.push_back(int'(char_out));
        end
        if (checking && rst_n) begin
            if (cyc == ins_due) exp_insync = ins_pend;
            chk("R11", "in_sync", int'(in_sync), int'(exp_insync));
            chk(cur_req, "char_valid", int'(char_valid), int'(cyc == v_due));
            if (cyc == v_due) begin
                chk(cur_req, "char_out", int'(char_out), v_data);
                chk(cur_req, "par_err", int'(par_err), v_err);
            end
        end
    end

    task automatic model_clear();
        hist.delete();
        m_state = 0; m_cnt = 0; m_val = 0;
    endtask

    task automatic sched(int val, int e, int due);
        v_due = due; v_data = val; v_err = e;
    endtask

    task automatic model_bit(bit b, int due);
        int code, win, e;
        bit hit;
        hist.push_back(b);
        if (hist.size() > 8) void'(hist.pop_front());
        code = cfg_sync_sel ? int'(sync_b) : int'(sync_a);
        win = 0;
        foreach (hist[i]) win |= int'(hist[i]) << i;
        hit = (hist.size() == 8) && (win == code);
        case (m_state)
            0: if (hit) begin m_state = cfg_two_sync ? 1 : 2; m_cnt = 0; end
            1: begin
                m_cnt++;
                if (m_cnt == 8) begin m_cnt = 0; m_state = hit ? 2 : 0; end
            end
            2: begin
                m_val |= int'(b) << m_cnt;
                m_cnt++;
                if (m_cnt == 8 - int'(cfg_len)) begin
                    m_cnt = 0;
                    if (cfg_par_en) m_state = 3;
                    else begin sched(m_val, 0, due); m_val = 0; end
                end
            end
            default: begin
                e = ((($countones(m_val) + int'(b)) % 2) != int'(cfg_par_odd)) ? 1 : 0;
                sched(m_val, e, due);
                m_val = 0; m_state = 2;
            end
        endcase
        ins_pend = (m_state >= 2);
        ins_due = due;
    endtask

    // R9: state update three clocks after the presented edge
    task automatic send_bit(bit b);
        @(negedge clk);
        rx_data = b;
        ext_rx_clk = 1'b1;
        model_bit(b, cyc + 3);
        repeat (4) @(negedge clk);
        ext_rx_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_byte(int v, int n);
        for (int i = 0; i < n; i++) send_bit(v[i]);
    endtask

    task automatic send_char(int v, int n, bit corrupt);
        bit p;
        send_byte(v, n);
        if (cfg_par_en) begin
            p = 1'b0;
            for (int i = 0; i < n; i++) p ^= v[i];
            p = p ^ cfg_par_odd ^ corrupt;
            send_bit(p);
        end
    endtask

    task automatic do_resync();
        @(negedge clk);
        resync = 1'b1;
        model_clear();
        ins_pend = 0;
        ins_due = cyc + 1;
        @(negedge clk);
        resync = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        checking = 0;
        model_clear();
        exp_insync = 0; ins_pend = 0; ins_due = -1; v_due = -1;
        repeat (3) @(negedge clk);
        chk("R1", "reset char_valid", int'(char_valid), 0);
        chk("R1", "reset par_err", int'(par_err), 0);
        chk("R1", "reset in_sync", int'(in_sync), 0);
        chk("R1", "reset char_out", int'(char_out), 0);
        rst_n = 1'b1;
        r_rel = cyc;
    endtask

    task automatic int_run(logic [1:0] sel);
        int div;
        bit stream[$];
        int bytes[4];
        div = (CLK_HZ / BASE) >> sel;
        bytes = '{int'(sync_a), 'h3C, 'hA5, 'h0F};
        foreach (bytes[j]) for (int i = 0; i < 8; i++) stream.push_back(bytes[j][i]);
        ext_clk_present = 1'b0; cfg_baud = sel;
        cfg_len = 2'd0; cfg_par_en = 0; cfg_two_sync = 0; cfg_sync_sel = 0;
        do_reset();
        vtimes.delete(); vdata.delete();
        for (int k = 0; k < stream.size(); k++) begin
            while (cyc != r_rel + div / 2 + k * div) @(negedge clk);
            rx_data = stream[k];
        end
        while (cyc < r_rel + 34 * div) @(negedge clk);
        chk("R10", "internal char count", vtimes.size(), 3);
        if (vtimes.size() == 3) begin
            chk("R10", "first delivery cycle", vtimes[0] - r_rel, 16 * div);
            chk("R10", "char spacing", vtimes[1] - vtimes[0], 8 * div);
            chk("R10", "char spacing 2", vtimes[2] - vtimes[1], 8 * div);
            chk("R9", "internal data 0", vdata[0], 'h3C);
            chk("R9", "internal data 2", vdata[2], 'h0F);
        end
    endtask

    int n0, e0;

    initial begin
        do_reset();
        checking = 1;

        // R4 R6 R7: one-sync on code A, 8-bit, no parity
        cur_req = "R4 R6 R7";
        n0 = nvalid;
        send_byte('b01101, 5);
        send_byte(int'(sync_a), 8);
        chk("R4", "in_sync after one sync", int'(in_sync), 1);
        send_char('h5A, 8, 0);
        send_char(int'(sync_a), 8, 0);
        send_char('h00, 8, 0);
        repeat (4) @(negedge clk);
        chk("R7", "delivered count", nvalid - n0, 3);
        chk("R7", "sync-valued data", vdata[vdata.size() - 2], int'(sync_a));

        // R5 R6: two-sync on code B, failed confirmation then lock
        cfg_two_sync = 1; cfg_sync_sel = 1;
        do_resync();
        cur_req = "R5 R6";
        n0 = nvalid;
        send_byte(int'(sync_b), 8);
        send_byte('h11, 8);
        chk("R5", "no lock after mismatch", int'(in_sync), 0);
        send_byte(int'(sync_b), 8);
        send_byte(int'(sync_b), 8);
        chk("R5", "lock after two syncs", int'(in_sync), 1);
        send_char('h77, 8, 0);
        repeat (4) @(negedge clk);
        chk("R5", "delivered count", nvalid - n0, 1);

        // R2 R3: 7-bit even parity
        cfg_two_sync = 0; cfg_sync_sel = 0; cfg_len = 2'd1; cfg_par_en = 1; cfg_par_odd = 0;
        do_resync();
        cur_req = "R2 R3";
        n0 = nvalid; e0 = nerr;
        send_byte(int'(sync_a), 8);
        send_char('h55, 7, 0);
        send_char('h7F, 7, 1);
        repeat (4) @(negedge clk);
        chk("R3", "even parity count", nvalid - n0, 2);
        chk("R3", "even parity errors", nerr - e0, 1);

        // R2 R3: 5-bit odd parity
        cfg_len = 2'd3; cfg_par_odd = 1;
        do_resync();
        n0 = nvalid; e0 = nerr;
        send_byte(int'(sync_a), 8);
        send_char('h1F, 5, 0);
        send_char('h03, 5, 1);
        repeat (4) @(negedge clk);
        chk("R3", "odd parity count", nvalid - n0, 2);
        chk("R3", "odd parity errors", nerr - e0, 1);
        chk("R2", "5-bit value", vdata[vdata.size() - 2], 'h1F);

        // R2: 6-bit, no parity
        cfg_len = 2'd2; cfg_par_en = 0;
        do_resync();
        n0 = nvalid; e0 = nerr;
        send_byte(int'(sync_a), 8);
        send_char('h3F, 6, 0);
        send_char('h2A, 6, 0);
        repeat (4) @(negedge clk);
        chk("R2", "6-bit count", nvalid - n0, 2);
        chk("R3", "no errors without parity", nerr - e0, 0);

        // R8: resync mid-character discards partial bits
        do_resync();
        cur_req = "R8";
        n0 = nvalid;
        send_byte(int'(sync_a), 8);
        send_byte('b111, 3);
        do_resync();
        chk("R8", "in_sync after resync", int'(in_sync), 0);
        send_byte(int'(sync_a), 8);
        send_char('h15, 6, 0);
        repeat (4) @(negedge clk);
        chk("R8", "delivered after resync", nvalid - n0, 1);
        chk("R8", "clean character", vdata[vdata.size() - 1], 'h15);

        // R10 R9: internal divider at two rates
        checking = 0;
        int_run(2'd3);
        int_run(2'd1);

        finish_run();
    end
endmodule